// File: doc/BRIEF.md
# Quad Double-Buffered Converter Register Interface

This block is the digital front end of a four-channel, 12-bit converter driven from a parallel host bus. Each channel holds two registers in series: a staging register that the host writes, and a live register whose value goes to the converter core. A host selects the block with an active-low select, sets a read/write level and a 2-bit channel number, and then either places a 12-bit word on the shared bidirectional data bus (write) or takes the staged word of that channel back from the bus (read). A separate active-low load strobe moves all four staged words into the live registers in one clock cycle, so every channel changes at once.

An active-low clear input forces both registers of every channel to a preset code: mid-scale (0x800) when the build parameter `MID_RESET` is 1, zero when it is 0. The host bus is asynchronous to the system clock. Select, read/write and load pass through two-flop synchronizers, and writes and loads act once, on the detected assertion edge. The clear input resets the block asynchronously and is released in step with the clock. The data bus has no valid/ready handshake: a bus cycle is complete once the strobe has been held for the minimum pulse width, 80 ns for a write and 130 ns for a read. The host can neither stall the block nor be stalled by it. The block suits both usage styles: one load after each channel write, or four writes followed by a single load.

Top module: `quad_dac_regif`

## Requirements
- R1: While `clr_n` is low, and after it is released, every live and staged register holds the reset code: 0x800 when `MID_RESET`=1 (the default), 0x000 when it is 0.
- R2: A write (`sel_n` low with `rd_wr_n`=0) stores `dbus` into the staged register of the channel numbered `chan_addr` (0..3) and into no other channel.
- R3: A read (`sel_n` low with `rd_wr_n`=1) drives the staged register of channel `chan_addr` onto `dbus`; outside a read the block leaves `dbus` at high impedance.
- R4: A write leaves the live outputs `dac_code` unchanged until the next load.
- R5: An asserting (falling) edge of `load_n` copies all four staged registers into the live registers in the same clock cycle. Channel i appears on `dac_code[12*i+11:12*i]`.
- R6: When a write edge and a load edge are detected in the same cycle, the load transfers the staged values from before that write. The new word reaches `dac_code` only on the following load.
- R7: Clear takes priority: if `clr_n` falls together with a load or a write, all registers end at the reset code.
- R8: Single-buffer use (one load after each write) and double-buffer use (four writes, then one load) both give `dac_code` equal to the last staged words.
- R9: Each select assertion writes once. A change of `dbus` while `sel_n` stays low does not alter the stored word.
- R10: After a clear, a load with no writes in between drives the reset code on every channel, and a read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Active-low asynchronous clear to the reset code |
| sel_n | input | 1 | Active-low chip select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| chan_addr | input | 2 | Channel number for a read or write |
| load_n | input | 1 | Active-low load strobe, acts on its falling edge |
| dbus | inout | 12 | Shared bidirectional data bus |
| dac_code | output | 48 | Live codes of the four channels, channel 0 in the low bits |

## Verification
On every cycle, assertions check these properties: a detected write enables at most one channel and never overlaps a read drive; the staged register takes the sampled bus word one cycle after its write pulse; the live register takes the old staged value one cycle after a load and holds still at all other times. What only the bench scenarios can show is the behaviour seen at the pins: the exact reset code, readback through the tri-state bus, the ordering of a simultaneous write and load, clear winning over a load, one write per select, and the single-buffer and double-buffer sequences timed at the minimum pulse widths.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned NUM_CH = 4;

  function automatic logic [CODE_W-1:0] preset_code(input bit mid);
    logic [CODE_W-1:0] c;
    c = '0;
    if (mid) c[CODE_W-1] = 1'b1;
    return c;
  endfunction
endpackage

// File: rtl/clr_sync.sv
module clr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/level_sync.sv
module level_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= INIT;
          else        stg_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= INIT;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/bus_ctl.sv
module bus_ctl #(
  parameter int unsigned CH     = 4,
  parameter int unsigned DW     = 12,
  parameter int unsigned STAGES = 2,
  localparam int unsigned AW    = $clog2(CH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          rd_wr_n,
  input  logic          load_n,
  input  logic [AW-1:0] chan_addr,
  output logic [CH-1:0] wr_sel,
  output logic          ld_stb,
  output logic          rd_oe
);
  logic cs_s, rd_s, ld_s;
  logic wr_cond, wr_prev_q, ld_prev_q, wr_stb;

  level_sync #(.STAGES(STAGES), .INIT(1'b0)) u_cs (
    .clk(clk), .rst_n(rst_n), .d_async(~sel_n), .q_sync(cs_s));
  level_sync #(.STAGES(STAGES), .INIT(1'b1)) u_rw (
    .clk(clk), .rst_n(rst_n), .d_async(rd_wr_n), .q_sync(rd_s));
  level_sync #(.STAGES(STAGES), .INIT(1'b0)) u_ld (
    .clk(clk), .rst_n(rst_n), .d_async(~load_n), .q_sync(ld_s));

  assign wr_cond = cs_s & ~rd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      ld_prev_q <= 1'b0;
    end else begin
      wr_prev_q <= wr_cond;
      ld_prev_q <= ld_s;
    end
  end

  assign wr_stb = wr_cond & ~wr_prev_q;
  assign ld_stb = ld_s & ~ld_prev_q;
  assign rd_oe  = cs_s & rd_s;

  always_comb begin
    wr_sel = '0;
    for (int i = 0; i < CH; i++)
      if (wr_stb && chan_addr == AW'(i)) wr_sel[i] = 1'b1;
  end

  // R9: a strobe lasts exactly one cycle per held select
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel != '0) |=> (wr_sel == '0));
endmodule

// File: rtl/chan_reg.sv
module chan_reg #(
  parameter int unsigned DW    = 12,
  parameter logic [DW-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          ld_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] stage_q,
  output logic [DW-1:0] live_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RST;
      live_q  <= RST;
    end else begin
      if (wr_en) stage_q <= wr_data;
      if (ld_en) live_q  <= stage_q;
    end
  end

  // R2: staged register takes the bus word after a write pulse
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stage_q == $past(wr_data)));
  // R5/R6: load moves the staged value present before any same-cycle write
  a_r5_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (live_q == $past(stage_q)));
  // R4: live value holds without a load
  a_r4_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> $stable(live_q));
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import quad_dac_pkg::*;
#(
  parameter int unsigned CH       = NUM_CH,
  parameter int unsigned DW       = CODE_W,
  parameter int unsigned STAGES   = 2,
  parameter bit          MID_RESET = 1'b1,
  localparam int unsigned AW      = $clog2(CH)
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             sel_n,
  input  logic             rd_wr_n,
  input  logic [AW-1:0]    chan_addr,
  input  logic             load_n,
  inout  wire  [DW-1:0]    dbus,
  output logic [CH*DW-1:0] dac_code
);
  localparam logic [DW-1:0] RST_CODE = DW'(preset_code(MID_RESET));

  logic          rst_n;
  logic [CH-1:0] wr_sel;
  logic          ld_stb;
  logic          rd_oe;
  logic [DW-1:0] stage_arr [CH];
  logic [DW-1:0] rd_word;

  clr_sync #(.STAGES(STAGES)) u_rst (.clk(clk), .clr_n(clr_n), .rst_n(rst_n));

  bus_ctl #(.CH(CH), .DW(DW), .STAGES(STAGES)) u_bus (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr_n(rd_wr_n),
    .load_n(load_n), .chan_addr(chan_addr),
    .wr_sel(wr_sel), .ld_stb(ld_stb), .rd_oe(rd_oe));

  generate
    for (genvar c = 0; c < CH; c++) begin : g_ch
      chan_reg #(.DW(DW), .RST(RST_CODE)) u_ch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[c]), .ld_en(ld_stb),
        .wr_data(dbus), .stage_q(stage_arr[c]),
        .live_q(dac_code[c*DW +: DW]));
    end
  endgenerate

  assign rd_word = stage_arr[chan_addr];
  assign dbus    = rd_oe ? rd_word : {DW{1'bz}};

  // R2: at most one channel written per cycle
  a_r2_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
  // R3: the block never drives the bus in a cycle that writes from it
  a_r3_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel != '0) |-> !rd_oe);
endmodule

// File: tb/sim_quad_dac_regif.sv
module sim_quad_dac_regif;
  localparam int DW = 12;
  localparam int CH = 4;
  localparam logic [DW-1:0] RSTV = 12'h800;

  logic clk = 1'b0;
  logic clr_n = 1'b0, sel_n = 1'b1, rd_wr_n = 1'b1, load_n = 1'b1;
  logic [1:0] chan_addr = '0;
  logic [DW-1:0] tb_d = '0;
  logic tb_oe = 1'b0;
  wire  [DW-1:0] dbus;
  logic [CH*DW-1:0] dac_code;

  assign dbus = tb_oe ? tb_d : {DW{1'bz}};

  always #2.5 clk = ~clk;

  quad_dac_regif u0 (.clk(clk), .clr_n(clr_n), .sel_n(sel_n), .rd_wr_n(rd_wr_n),
    .chan_addr(chan_addr), .load_n(load_n), .dbus(dbus), .dac_code(dac_code));

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] stg_m [CH];
  logic [DW-1:0] live_m [CH];

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] live_of(input int c);
    return dac_code[c*DW +: DW];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input int c, input logic [DW-1:0] v);
    chan_addr = 2'(c); rd_wr_n = 1'b0; tb_d = v; tb_oe = 1'b1;
    cyc(1);
    sel_n = 1'b0;
    cyc(20);
    sel_n = 1'b1;
    cyc(4);
    tb_oe = 1'b0; rd_wr_n = 1'b1;
    cyc(2);
    stg_m[c] = v;
  endtask

  task automatic bus_read(input int c, output logic [DW-1:0] v);
    chan_addr = 2'(c); rd_wr_n = 1'b1; tb_oe = 1'b0;
    cyc(1);
    sel_n = 1'b0;
    cyc(20);
    v = dbus;
    cyc(8);
    sel_n = 1'b1;
    cyc(6);
  endtask

  task automatic pulse_load();
    load_n = 1'b0;
    cyc(10);
    load_n = 1'b1;
    cyc(4);
    for (int c = 0; c < CH; c++) live_m[c] = stg_m[c];
  endtask

  task automatic check_live(input string tag);
    for (int c = 0; c < CH; c++) chk($sformatf("%s live ch%0d", tag, c), live_of(c), live_m[c]);
  endtask

  task automatic check_read(input string tag, input int c);
    logic [DW-1:0] v;
    bus_read(c, v);
    chk($sformatf("%s read ch%0d", tag, c), v, stg_m[c]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [DW-1:0] v, old0;
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int c = 0; c < CH; c++) begin stg_m[c] = RSTV; live_m[c] = RSTV; end

    // R1: state during and after clear
    cyc(3);
    chk("R1 live ch0 in clear", live_of(0), RSTV);
    clr_n = 1'b1;
    cyc(6);
    check_live("R1 after release");
    // R10: load with no writes keeps reset code, readback reset code
    pulse_load();
    check_live("R10 load after clear");
    check_read("R10", 2);

    // R2 / R4: writes reach only staged register; live unchanged
    bus_write(1, 12'h5A3);
    check_live("R4 after write");
    check_read("R2 target", 1);
    check_read("R2 neighbour", 0);
    check_read("R3 readback", 3);

    // R8 single-buffer style
    for (int c = 0; c < CH; c++) begin
      bus_write(c, 12'h100 + 12'(c * 16'h111));
      pulse_load();
      check_live("R8 single-buffer");
    end
    // R8 double-buffer style
    for (int c = 0; c < CH; c++) bus_write(c, 12'hF00 - 12'(c * 3));
    check_live("R4 pending double-buffer");
    pulse_load();
    check_live("R8 R5 double-buffer");

    // R9: data changes while select held does not rewrite
    chan_addr = 2'd2; rd_wr_n = 1'b0; tb_d = 12'h0C3; tb_oe = 1'b1;
    cyc(1); sel_n = 1'b0; cyc(10);
    tb_d = 12'h3C0; cyc(10);
    sel_n = 1'b1; cyc(4); tb_oe = 1'b0; rd_wr_n = 1'b1; cyc(2);
    stg_m[2] = 12'h0C3;
    check_read("R9 held select", 2);

    // R6: write and load edges in the same cycle
    old0 = stg_m[0];
    chan_addr = 2'd0; rd_wr_n = 1'b0; tb_d = 12'hABC; tb_oe = 1'b1;
    cyc(1);
    sel_n = 1'b0; load_n = 1'b0;
    cyc(20);
    sel_n = 1'b1; load_n = 1'b1;
    cyc(4); tb_oe = 1'b0; rd_wr_n = 1'b1; cyc(2);
    for (int c = 0; c < CH; c++) live_m[c] = stg_m[c];
    stg_m[0] = 12'hABC;
    chk("R6 live ch0 old value", live_of(0), old0);
    check_live("R6 same-cycle");
    check_read("R6 staged new", 0);
    pulse_load();
    chk("R6 next load new value", live_of(0), 12'hABC);

    // R7: clear together with a load
    bus_write(3, 12'h777);
    load_n = 1'b0; clr_n = 1'b0;
    cyc(8);
    load_n = 1'b1;
    cyc(2);
    clr_n = 1'b1;
    cyc(6);
    for (int c = 0; c < CH; c++) begin stg_m[c] = RSTV; live_m[c] = RSTV; end
    check_live("R7 clear over load");
    check_read("R7 staged cleared", 3);

    // Random mix of writes, reads and loads
    for (int it = 0; it < 60; it++) begin
      int op, c;
      op = int'($urandom_range(0, 3));
      c  = int'($urandom_range(0, CH-1));
      case (op)
        0, 1: begin
          bus_write(c, 12'($urandom));
          chk($sformatf("R4 random live ch%0d", c), live_of(c), live_m[c]);
        end
        2: check_read("R3 random", c);
        default: begin pulse_load(); check_live("R5 random"); end
      endcase
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule